// File: doc/BRIEF.md
# I2C Byte-Command Master Engine

This block is the bit-level core of an I2C bus master that software steers one byte at a time. A single write of a six-bit one-hot command word starts one or more bus phases: a START condition, the transmission of one byte, the reception of one byte, and a STOP condition. When several phases are requested in the same write they run in a fixed order: START, then transmit, then receive, then STOP. Sequences across several messages and any length logic stay with the controlling software.

Bus timing comes from an external tick. Every bit takes four ticks: set up data, release SCL, sample while SCL is high, pull SCL low. The engine drives SDA and SCL as open-drain enables (1 pulls the line low) and samples both lines back. A target may hold SCL low to stretch the clock, and a stretch that lasts too long aborts the transfer. Each completed or failed phase sets its own sticky status bit. Status bits are cleared by writing ones. An interrupt line combines the set bits with a per-bit enable mask.

Top module: `i2cm_cmd_engine`

## Requirements
- R1: After reset both line drives are released (0), all status bits are 0, the interrupt is 0 and the received byte is 0.
- R2: START and transmit (command bits 0 and 1) together send the transmit byte as the address byte. An ACK from the target sets status bit 0 and a NACK sets status bit 1.
- R3: A transmit phase sends the transmit byte MSB first, and SDA changes only while SCL is low.
- R4: A receive phase (command bit 3) shifts in one byte MSB first, presents it on the received-byte output and sets status bit 2. The master answers with ACK, unless the last flag (command bit 4) is also set, in which case it answers with NACK.
- R5: START, transmit, receive and STOP written in a single command run in that order and set status bits 0, 2 and 4.
- R6: A STOP phase (command bit 5) raises SDA while SCL is high, leaves both lines released and sets status bit 4.
- R7: Status bits stay set until cleared. Writing a clear mask clears exactly the bits that are 1 in the mask and leaves the other bits unchanged.
- R8: The interrupt output is 1 exactly when some status bit and its enable bit are both 1.
- R9: During transmit, if SDA reads low while the engine is releasing it for a 1 bit, status bit 3 is set. The engine then releases both lines and drops the phases still pending, including a STOP.
- R10: If SCL stays low for the timeout number of ticks after the engine releases it, status bit 6 is set. The engine then releases both lines, drops the pending phases and gives up ownership of the bus.
- R11: A transmit or receive command without START, issued while the engine does not own the bus, sets status bit 5 and puts nothing on the bus.
- R12: Command bit 2 alone has no effect: no status bit is set and both lines stay released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle strobe that writes a command word |
| cmd | input | 6 | One-hot command bits: 0 START, 1 transmit, 2 no effect, 3 receive, 4 last, 5 STOP |
| tx_byte | input | 8 | Byte to transmit; held stable while a transmit runs |
| tick | input | 1 | Quarter-bit timing tick |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| rx_byte | output | 8 | Last received byte |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| irq_en | input | 7 | Interrupt enable, one bit per status bit |
| clr_wr | input | 1 | Strobe that applies the clear mask |
| clr_bits | input | 7 | Status bits to clear (1 clears) |
| sts | output | 7 | Status: 0 ACK, 1 NACK, 2 received, 3 lost arbitration, 4 stopped, 5 bad command, 6 SCL timeout |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check on every cycle that status bits are sticky and clear only where the mask has ones. They also check that SDA stays put while SCL is high inside a data bit, that a last-flagged receive never drives an ACK, and that every error or stop event leaves the engine idle with both lines released. Only the bench scenarios can show that byte values cross the bus intact, MSB first, and that a combined command produces the right phase order. The same holds for a target NACK, a jammed SDA and a held SCL each ending in their own status bit, and for the interrupt following the enable mask.

// File: rtl/i2cm_cmd_engine.sv
module i2cm_cmd_engine #(
  parameter int TMO_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [5:0] cmd,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       sda_in,
  input  logic       scl_in,
  output logic [7:0] rx_byte,
  output logic       sda_oe,
  output logic       scl_oe,
  input  logic [6:0] irq_en,
  input  logic       clr_wr,
  input  logic [6:0] clr_bits,
  output logic [6:0] sts,
  output logic       irq
);

  localparam int TW = $clog2(TMO_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t          st;
  logic [5:0]   pend;
  logic         owned;
  logic [1:0]   q;
  logic [3:0]   bc;
  logic [7:0]   sh;
  logic         is_rx;
  logic         nak;
  logic [TW-1:0] tmo;
  logic [6:0]   ev;

  wire [6:0] clr_mask = clr_wr ? clr_bits : 7'd0;
  wire       ack_bit  = (bc == 4'd8);

  assign irq = |(sts & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_mask) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= '0; owned <= 1'b0; q <= '0; bc <= '0;
      sh <= '0; is_rx <= 1'b0; nak <= 1'b0; tmo <= '0; ev <= '0;
      sda_oe <= 1'b0; scl_oe <= 1'b0; rx_byte <= '0;
    end else begin
      ev <= '0;
      case (st)
        S_IDLE: begin
          q <= '0;
          if (cmd_wr) begin
            if ((cmd[1] | cmd[3]) && !cmd[0] && !owned) begin
              ev[5] <= 1'b1;
              pend  <= '0;
            end else begin
              pend <= cmd & 6'b111011;
            end
          end else if (pend[0]) begin
            st <= S_START;
          end else if (pend[1]) begin
            st <= S_BIT; is_rx <= 1'b0; sh <= tx_byte; bc <= '0;
          end else if (pend[3]) begin
            st <= S_BIT; is_rx <= 1'b1; bc <= '0;
          end else if (pend[5]) begin
            st <= S_STOP;
          end else if (pend != 6'd0) begin
            pend <= '0;
          end
        end
        S_START: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe <= 1'b1; st <= S_IDLE; pend[0] <= 1'b0; owned <= 1'b1;
            end
          endcase
        end
        S_BIT: if (tick) begin
          case (q)
            2'd0: begin
              if (ack_bit) sda_oe <= is_rx ? !pend[4] : 1'b0;
              else         sda_oe <= is_rx ? 1'b0 : !sh[7];
              q <= 2'd1;
            end
            2'd1: begin
              scl_oe <= 1'b0; q <= 2'd2;
            end
            2'd2: begin
              if (!scl_in) begin
                if (tmo == TW'(TMO_TICKS - 1)) begin
                  ev[6] <= 1'b1; st <= S_IDLE; pend <= '0; owned <= 1'b0;
                  sda_oe <= 1'b0; scl_oe <= 1'b0; tmo <= '0;
                end else begin
                  tmo <= tmo + 1'b1;
                end
              end else begin
                tmo <= '0;
                q   <= 2'd3;
                if (ack_bit) begin
                  nak <= sda_in;
                end else if (is_rx) begin
                  sh <= {sh[6:0], sda_in};
                end else if (!sda_oe && !sda_in) begin
                  ev[3] <= 1'b1; st <= S_IDLE; pend <= '0; owned <= 1'b0;
                  sda_oe <= 1'b0; scl_oe <= 1'b0;
                end
              end
            end
            default: begin
              scl_oe <= 1'b1;
              q <= 2'd0;
              if (ack_bit) begin
                st <= S_IDLE;
                if (is_rx) begin
                  rx_byte <= sh; ev[2] <= 1'b1; pend[3] <= 1'b0; pend[4] <= 1'b0;
                end else begin
                  ev[0] <= !nak; ev[1] <= nak; pend[1] <= 1'b0;
                end
              end else begin
                bc <= bc + 4'd1;
                if (!is_rx) sh <= {sh[6:0], 1'b0};
              end
            end
          endcase
        end
        default: if (tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              st <= S_IDLE; pend[5] <= 1'b0; owned <= 1'b0; ev[4] <= 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((($past(sts) & ~$past(clr_mask))) & ~sts) == 7'd0));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((ev & clr_bits) == 7'd0)) |=> ((sts & $past(clr_bits)) == 7'd0));

  a_r3_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && !scl_oe && !$past(scl_oe) && $past(st) == S_BIT) |-> $stable(sda_oe));

  a_r4_last_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && is_rx && ack_bit && pend[4] && q != 2'd0) |-> !sda_oe);

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[3] | ev[5] | ev[6]) |-> (st == S_IDLE && pend == 6'd0 && !sda_oe && !scl_oe));

  a_r6_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
    ev[4] |-> (!sda_oe && !scl_oe && !owned && st == S_IDLE));

endmodule

// File: tb/test_i2cm_cmd_engine.sv
module test_i2cm_cmd_engine;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [5:0] cmd = '0;
  logic [7:0] tx_byte = '0;
  logic       tick = 1'b0;
  logic [6:0] irq_en = '0;
  logic       clr_wr = 1'b0;
  logic [6:0] clr_bits = '0;
  logic [7:0] rx_byte;
  logic       sda_oe, scl_oe, irq;
  logic [6:0] sts;

  logic stretch = 1'b0, jam = 1'b0, sl_drv = 1'b0, ack_en = 1'b1;
  logic [7:0] sl_byte = '0;
  wire scl_w = ~(scl_oe | stretch);
  wire sda_w = ~(sda_oe | sl_drv | jam);

  int nchk = 0, nfail = 0;

  i2cm_cmd_engine #(.TMO_TICKS(16)) i_i2cm_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd), .tx_byte(tx_byte),
    .tick(tick), .sda_in(sda_w), .scl_in(scl_w), .rx_byte(rx_byte),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .irq_en(irq_en), .clr_wr(clr_wr),
    .clr_bits(clr_bits), .sts(sts), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  // target model
  logic prev_scl = 1'b1, prev_sda = 1'b1, started = 1'b0, rd = 1'b0, done = 1'b0;
  int bitn = 0, byten = 0, nstops = 0, nrcv = 0;
  logic [7:0] shreg = '0, last_rcv = '0, addr_rcv = '0;
  logic mack = 1'b0;

  always @(scl_w, sda_w) begin
    if (prev_scl === 1'b1 && scl_w === 1'b1 && prev_sda === 1'b1 && sda_w === 1'b0) begin
      started = 1'b1; bitn = -1; byten = 0; rd = 1'b0; done = 1'b0; sl_drv = 1'b0;
    end else if (prev_scl === 1'b1 && scl_w === 1'b1 && prev_sda === 1'b0 && sda_w === 1'b1) begin
      started = 1'b0; nstops++; sl_drv = 1'b0;
    end else if (prev_scl === 1'b0 && scl_w === 1'b1 && started) begin
      if (bitn >= 0 && bitn < 8) shreg = {shreg[6:0], sda_w};
      if (bitn == 8) begin
        if (byten == 0) addr_rcv = shreg;
        else if (!rd) begin last_rcv = shreg; nrcv++; end
        else begin mack = sda_w; if (sda_w) done = 1'b1; end
      end
    end else if (prev_scl === 1'b1 && scl_w === 1'b0 && started) begin
      bitn++;
      if (bitn == 9) begin bitn = 0; byten++; end
      if (bitn == 8) begin
        if (byten == 0) begin rd = shreg[0]; sl_drv = ack_en; end
        else if (!rd) sl_drv = ack_en;
        else sl_drv = 1'b0;
      end else if (rd && byten > 0 && !done) sl_drv = !sl_byte[7-bitn];
      else sl_drv = 1'b0;
    end
    prev_scl = scl_w; prev_sda = sda_w;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [5:0] c);
    @(negedge clk); cmd = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic do_clr(input logic [6:0] m);
    @(negedge clk); clr_bits = m; clr_wr = 1'b1;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  task automatic wait_sts(input logic [6:0] m, input string req);
    int n;
    n = 0;
    while ((sts & m) == 7'd0 && n < 3000) begin @(negedge clk); n++; end
    check(req, int'(n < 3000), 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sts", sts, 0);
    check("R1 sda", sda_oe, 0);
    check("R1 scl", scl_oe, 0);
    check("R1 irq", irq, 0);
    check("R1 rx", rx_byte, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 slave-transmit bit alone
    do_cmd(6'b000100);
    repeat (60) @(negedge clk);
    check("R12 sts", sts, 0);
    check("R12 lines", {sda_oe, scl_oe}, 0);

    // R11 transmit without owning the bus
    s0 = nstops;
    do_cmd(6'b000010);
    repeat (60) @(negedge clk);
    check("R11 sts", sts, 7'h20);
    check("R11 lines", {sda_oe, scl_oe}, 0);
    check("R11 no bus activity", nstops, s0);
    do_clr(7'h7F);

    // R2 R3 R6 write sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a, d;
      a = {7'h50 + 7'(i), 1'b0};
      d = 8'(i * 37 + 5);
      if (i == 1) d = 8'hFF;
      if (i == 2) d = 8'h00;
      ack_en = 1'b1;
      tx_byte = a;
      do_cmd(6'b000011);
      wait_sts(7'h03, "R2 wait");
      check("R2 addr ack", sts, 7'h01);
      check("R2 addr seen", addr_rcv, a);
      do_clr(7'h7F);
      tx_byte = d;
      do_cmd(6'b000010);
      wait_sts(7'h03, "R3 wait");
      check("R3 ack", sts, 7'h01);
      check("R3 byte seen", last_rcv, d);
      do_clr(7'h7F);
      s0 = nstops;
      do_cmd(6'b100000);
      wait_sts(7'h10, "R6 wait");
      check("R6 sts", sts, 7'h10);
      check("R6 stop seen", nstops, s0 + 1);
      check("R6 lines", {sda_oe, scl_oe}, 0);
      do_clr(7'h7F);
    end

    // R2 no target
    ack_en = 1'b0;
    tx_byte = 8'h6C;
    do_cmd(6'b000011);
    wait_sts(7'h03, "R2 wait nak");
    check("R2 nak", sts, 7'h02);
    do_clr(7'h7F);
    do_cmd(6'b100000);
    wait_sts(7'h10, "R6 wait2");
    check("R6 after nak", sts, 7'h10);
    do_clr(7'h7F);
    ack_en = 1'b1;

    // R4 R5 combined read sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 53 + 3);
      sl_byte = v;
      tx_byte = {7'h21, 1'b1};
      s0 = nstops;
      do_cmd(6'b111011);
      wait_sts(7'h10, "R5 wait");
      check("R5 order status", sts, 7'h15);
      check("R4 rx byte", rx_byte, v);
      check("R4 last nack", mack, 1);
      check("R5 stop", nstops, s0 + 1);
      if (i == 7) begin
        // R8 interrupt mask sweep with sts = 15h
        for (int e = 0; e < 128; e++) begin
          @(negedge clk); irq_en = 7'(e);
          #1 check("R8 irq", irq, int'(|(7'h15 & 7'(e))));
        end
        irq_en = '0;
        // R7 clear patterns
        do_clr(7'h01); check("R7 clr1", sts, 7'h14);
        do_clr(7'h40); check("R7 clr unset", sts, 7'h14);
        do_clr(7'h10); check("R7 clr stop", sts, 7'h04);
        do_clr(7'h00); check("R7 clr none", sts, 7'h04);
      end
      do_clr(7'h7F);
      check("R7 clr all", sts, 0);
    end

    // R4 two-byte read with ACK then NACK
    sl_byte = 8'hA5;
    tx_byte = {7'h22, 1'b1};
    do_cmd(6'b001011);
    wait_sts(7'h04, "R4 wait ack");
    check("R4 first byte", rx_byte, 8'hA5);
    check("R4 ack", mack, 0);
    do_clr(7'h7F);
    do_cmd(6'b111000);
    wait_sts(7'h10, "R4 wait last");
    check("R4 second status", sts, 7'h14);
    check("R4 second byte", rx_byte, 8'hA5);
    check("R4 nack", mack, 1);
    do_clr(7'h7F);

    // R9 arbitration loss
    jam = 1'b1;
    tx_byte = 8'hFF;
    do_cmd(6'b100011);
    wait_sts(7'h7F, "R9 wait");
    check("R9 sts", sts, 7'h08);
    check("R9 lines", {sda_oe, scl_oe}, 0);
    repeat (150) @(negedge clk);
    check("R9 stop dropped", sts, 7'h08);
    jam = 1'b0;
    do_clr(7'h7F);

    // R10 SCL held low
    stretch = 1'b1;
    tx_byte = 8'h40;
    do_cmd(6'b100011);
    wait_sts(7'h7F, "R10 wait");
    check("R10 sts", sts, 7'h40);
    check("R10 lines", {sda_oe, scl_oe}, 0);
    repeat (150) @(negedge clk);
    check("R10 queue dropped", sts, 7'h40);
    stretch = 1'b0;
    do_clr(7'h7F);
    do_cmd(6'b001000);
    repeat (60) @(negedge clk);
    check("R11 after timeout", sts, 7'h20);
    check("R11 lines2", {sda_oe, scl_oe}, 0);
    do_clr(7'h7F);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule